// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Engine

This block copies data between addresses on a simple request/acknowledge memory bus, using two independent channels. Each channel has four registers: a source pointer, a destination pointer, a 24-bit unit counter and a 16-bit control word. A shared operation register holds a global enable. Shared registers also hold one interrupt vector per channel and an interrupt level. Software programs a channel, then either writes its control word or raises the global enable. The channel arms if the global enable is on, its enable bit is set and its end flag is clear.

An armed channel moves one unit at a time. A unit is 1, 2, 4 or 16 bytes, and each unit is a read followed by a write. A 16-byte unit is split into four 32-bit read/write pairs. Pacing is either automatic, with units back to back, or one unit per sample of the channel's external request line. When the counter reaches zero the channel sets its end flag and drops out. If its interrupt enable is set, it also emits a one-cycle interrupt that carries a level and the channel's vector. Channel 0 wins whenever both channels are ready in the same cycle.

Top module: `dma2ch`

## Requirements
- R1: Registers sit at word index reg_addr[5:2]: 0..3 are source, destination, count and control of channel 0; 4..7 are the same for channel 1; 8 is the operation register (bit 0 = global enable); 9 and 10 are the vectors of channels 0 and 1 (7 bits kept); 11 is the level register (low nibble used). The count keeps only its low 24 bits and reads back 0 in bits 31:24.
- R2: Control bit 11:10 selects the unit: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes. mem_size reports 0, 1 or 2 for 1, 2 or 4 bytes. A 16-byte unit is four 4-byte read/write pairs at offsets 0, 4, 8 and 12.
- R3: Control bits 13:12 (source) and 15:14 (destination) give the pointer step after each unit: 1 adds the unit size, 2 subtracts it, and 0 or 3 leaves the pointer unchanged. With 16-byte units the source always advances by 16.
- R4: A channel arms only when the global enable is 1, control bit 0 (enable) is 1 and control bit 1 (end flag) is 0.
- R5: Arming is evaluated after any write to either channel's control word and on a 0-to-1 change of the global enable, and at no other time.
- R6: The count drops by one per finished unit. An armed channel with control bit 9 set runs units back to back until the count is zero. An armed channel with a zero count finishes without any bus access.
- R7: With control bit 9 clear, each unit waits for a high sample of that channel's dreq input while the engine is idle.
- R8: On finishing, the end flag (control bit 1) becomes 1. Writing 0 to that bit clears it, and writing 1 to it leaves it unchanged.
- R9: On finishing with control bit 2 set, irq pulses for one cycle with irq_level = level register[3:0] and irq_vector = the channel's vector[6:0].
- R10: When both channels are ready in the same idle cycle, channel 0 is served first.
- R11: Each memory access holds mem_req, mem_we and mem_addr steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dreq | input | 2 | External unit request, one per channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ack | input | 1 | Access accepted this cycle |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_level | output | 4 | Interrupt level |
| irq_vector | output | 7 | Interrupt vector |

## Verification
The bench builds the block with its defaults: 32-bit addresses and a 24-bit counter, so the discard of the counter's top byte is visible at the register port. It sweeps every unit size against every source and destination step mode on a 256-byte memory model whose acknowledge stalls every other cycle. It compares the whole memory and the final pointers with values it computes from the step rules. Directed runs then cover the arming gates, request pacing, interrupts, zero-count starts and the channel-0 preference.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DW    = 32;
  localparam int B_EN  = 0;
  localparam int B_END = 1;
  localparam int B_IE  = 2;
  localparam int B_AUTO = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_t;

  function automatic logic [4:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0: unit_bytes = 5'd1;
      2'd1: unit_bytes = 5'd2;
      2'd2: unit_bytes = 5'd4;
      default: unit_bytes = 5'd16;
    endcase
  endfunction

  function automatic logic [DW-1:0] step_addr(input logic [DW-1:0] a,
                                              input logic [1:0] mode,
                                              input logic [1:0] sz);
    case (mode)
      2'd1: step_addr = a + DW'(unit_bytes(sz));
      2'd2: step_addr = a - DW'(unit_bytes(sz));
      default: step_addr = a;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          start_evt,
  input  logic          master_en,
  input  logic          unit_done,
  input  logic [AW-1:0] src_nxt,
  input  logic [AW-1:0] dst_nxt,
  input  logic          finish,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic [15:0]   ctrl,
  output logic          active
);
  logic arm_ok;
  assign arm_ok = start_evt && master_en && ctrl[B_EN] && !ctrl[B_END] && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0; ctrl <= '0; active <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_idx)
          2'd0: src <= wr_data[AW-1:0];
          2'd1: dst <= wr_data[AW-1:0];
          2'd2: cnt <= wr_data[CW-1:0];
          default: ctrl <= {wr_data[15:2], ctrl[B_END] & wr_data[B_END], wr_data[B_EN]};
        endcase
      end
      if (unit_done) begin
        src <= src_nxt;
        dst <= dst_nxt;
        cnt <= cnt - 1'b1;
      end
      if (arm_ok) active <= 1'b1;
      if (finish) begin
        ctrl[B_END] <= 1'b1;
        active <= 1'b0;
      end
    end
  end

  // R8: end flag only clears by a software write of 0
  a_r8_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_END] && !(wr_en && wr_idx == 2'd3 && !wr_data[B_END]) |=> ctrl[B_END]);
  // R4: arming only under the three-way enable
  a_r4_arm_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(master_en && ctrl[B_EN] && !ctrl[B_END]));
  // R6: the engine never completes a unit on an exhausted count
  a_r6_no_unit_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> cnt != '0);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           active,
  input  logic [1:0]           dreq,
  input  logic [1:0][AW-1:0]   src_a,
  input  logic [1:0][AW-1:0]   dst_a,
  input  logic [1:0][CW-1:0]   cnt_a,
  input  logic [1:0][15:0]     ctrl_a,
  output logic [1:0]           unit_done,
  output logic [1:0]           finish,
  output logic [AW-1:0]        src_nxt,
  output logic [AW-1:0]        dst_nxt,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [1:0]           mem_size,
  output logic [AW-1:0]        mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  input  logic                 mem_ack
);
  localparam int NCH = 2;

  eng_st_t     st;
  logic        ch;
  logic [1:0]  beat;
  logic [31:0] hold_q;
  logic [NCH-1:0] ready;
  logic        sel;
  logic [1:0]  sz;
  logic [4:0]  off;
  logic        unit_last;

  for (genvar i = 0; i < NCH; i++) begin : g_rdy
    assign ready[i] = active[i] && (cnt_a[i] == '0 || ctrl_a[i][B_AUTO] || dreq[i]);
  end

  assign sel       = ready[0] ? 1'b0 : 1'b1;
  assign sz        = ctrl_a[ch][11:10];
  assign off       = (sz == 2'd3) ? {1'b0, beat, 2'b00} : 5'd0;
  assign mem_req   = (st != ST_IDLE);
  assign mem_we    = (st == ST_WR);
  assign mem_size  = (sz == 2'd3) ? 2'd2 : sz;
  assign mem_addr  = ((st == ST_WR) ? dst_a[ch] : src_a[ch]) + AW'(off);
  assign mem_wdata = hold_q;
  assign unit_last = (st == ST_WR) && mem_ack && (sz != 2'd3 || beat == 2'd3);

  assign src_nxt = (sz == 2'd3) ? src_a[ch] + AW'(16)
                 : AW'(step_addr(DW'(src_a[ch]), ctrl_a[ch][13:12], sz));
  assign dst_nxt = AW'(step_addr(DW'(dst_a[ch]), ctrl_a[ch][15:14], sz));

  always_comb begin
    unit_done = '0;
    finish    = '0;
    if (unit_last) unit_done[ch] = 1'b1;
    if (st == ST_IDLE && (|ready) && cnt_a[sel] == '0) finish[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ch <= 1'b0; beat <= '0; hold_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (|ready) begin
          ch   <= sel;
          beat <= '0;
          if (cnt_a[sel] != '0) st <= ST_RD;
        end
        ST_RD: if (mem_ack) begin
          hold_q <= mem_rdata;
          st     <= ST_WR;
        end
        default: if (mem_ack) begin
          if (sz == 2'd3 && beat != 2'd3) begin
            beat <= beat + 1'b1;
            st   <= ST_RD;
          end else begin
            st <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R11: a pending access stays unchanged until accepted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R2: the bus never sees a size wider than a word
  a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);
  // R6: at most one channel event per cycle
  a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unit_done, finish}));
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [1:0]    dreq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          irq,
  output logic [3:0]    irq_level,
  output logic [6:0]    irq_vector
);
  localparam int NCH = 2;

  logic [NCH-1:0][AW-1:0] src_a, dst_a;
  logic [NCH-1:0][CW-1:0] cnt_a;
  logic [NCH-1:0][15:0]   ctrl_a;
  logic [NCH-1:0]         active, unit_done, finish;
  logic [AW-1:0]          src_nxt, dst_nxt;
  logic                   op_en, en_q, ctrl_wr_q, start_evt;
  logic [NCH-1:0][6:0]    vec;
  logic [7:0]             lvl_reg;
  logic [3:0]             widx;

  assign widx      = reg_addr[5:2];
  assign start_evt = ctrl_wr_q | (op_en & ~en_q);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && !reg_addr[5] && reg_addr[4] == i[0]),
      .wr_idx(reg_addr[3:2]), .wr_data(reg_wdata),
      .start_evt(start_evt), .master_en(op_en),
      .unit_done(unit_done[i]), .src_nxt(src_nxt), .dst_nxt(dst_nxt),
      .finish(finish[i]),
      .src(src_a[i]), .dst(dst_a[i]), .cnt(cnt_a[i]), .ctrl(ctrl_a[i]),
      .active(active[i])
    );
  end

  dma_engine #(.AW(AW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .active(active), .dreq(dreq),
    .src_a(src_a), .dst_a(dst_a), .cnt_a(cnt_a), .ctrl_a(ctrl_a),
    .unit_done(unit_done), .finish(finish),
    .src_nxt(src_nxt), .dst_nxt(dst_nxt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_en <= 1'b0; en_q <= 1'b0; ctrl_wr_q <= 1'b0;
      vec <= '0; lvl_reg <= '0;
      irq <= 1'b0; irq_level <= '0; irq_vector <= '0;
    end else begin
      en_q      <= op_en;
      ctrl_wr_q <= reg_wr && !reg_addr[5] && reg_addr[3:2] == 2'd3;
      if (reg_wr) begin
        case (widx)
          4'd8:  op_en   <= reg_wdata[0];
          4'd9:  vec[0]  <= reg_wdata[6:0];
          4'd10: vec[1]  <= reg_wdata[6:0];
          4'd11: lvl_reg <= reg_wdata[7:0];
          default: ;
        endcase
      end
      irq <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        if (finish[i] && ctrl_a[i][B_IE]) begin
          irq        <= 1'b1;
          irq_level  <= lvl_reg[3:0];
          irq_vector <= vec[i];
        end
      end
    end
  end

  always_comb begin
    case (widx)
      4'd0:  reg_rdata = 32'(src_a[0]);
      4'd1:  reg_rdata = 32'(dst_a[0]);
      4'd2:  reg_rdata = 32'(cnt_a[0]);
      4'd3:  reg_rdata = {16'd0, ctrl_a[0]};
      4'd4:  reg_rdata = 32'(src_a[1]);
      4'd5:  reg_rdata = 32'(dst_a[1]);
      4'd6:  reg_rdata = 32'(cnt_a[1]);
      4'd7:  reg_rdata = {16'd0, ctrl_a[1]};
      4'd8:  reg_rdata = {31'd0, op_en};
      4'd9:  reg_rdata = {25'd0, vec[0]};
      4'd10: reg_rdata = {25'd0, vec[1]};
      4'd11: reg_rdata = {24'd0, lvl_reg};
      default: reg_rdata = '0;
    endcase
  end

  // R9: an interrupt always follows a channel reaching its end flag
  a_r9_irq_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_a[0][B_END] || ctrl_a[1][B_END]));
  // R5: no channel arms without the global enable
  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en && !$past(op_en) && $past(active) == '0 |-> active == '0);
endmodule

// File: tb/sim_dma2ch.sv
`timescale 1ns/1ps
module sim_dma2ch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dreq = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;
  logic [3:0]  irq_level;
  logic [6:0]  irq_vector;

  int checks = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] refm [256];
  logic ack_gate = 1'b0;
  logic seen_rd = 1'b0;
  logic [31:0] first_rd = '0;
  int irq_cnt = 0;
  logic [3:0] last_lvl = '0;
  logic [6:0] last_vec = '0;

  always #2 clk = ~clk;

  dma2ch u0 (.*);

  assign mem_ack = mem_req & ack_gate;
  assign mem_rdata = {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                      mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};

  always @(posedge clk) begin
    ack_gate <= ~ack_gate;
    if (mem_req && mem_ack && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_size >= 2'd1) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
      if (mem_size == 2'd2) begin
        mem[8'(mem_addr[7:0] + 8'd2)] <= mem_wdata[23:16];
        mem[8'(mem_addr[7:0] + 8'd3)] <= mem_wdata[31:24];
      end
    end
    if (mem_req && !mem_we && !seen_rd) begin
      seen_rd  <= 1'b1;
      first_rd <= mem_addr;
    end
    if (irq) begin
      irq_cnt  <= irq_cnt + 1;
      last_lvl <= irq_level;
      last_vec <= irq_vector;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(idx * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(idx * 4);
    #1 d = reg_rdata;
  endtask

  task automatic wait_end(input int c, input string tag);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(c * 4 + 3, v);
      if (v[1]) return;
    end
    chk(tag, 32'd0, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_dreq(input int c);
    @(negedge clk); dreq[c] = 1'b1;
    @(negedge clk); dreq[c] = 1'b0;
  endtask

  localparam logic [31:0] EN = 32'h1, AUTO = 32'h200, IE = 32'h4;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nb, s, d, bad, ic;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(3, v); chk("R8 reset control", v, 0);
    rd(2, v); chk("R1 reset count", v, 0);
    chk("R9 reset irq", 32'(irq), 0);
    // R1: top byte of the count discarded
    wr(2, 32'hFF00_0005); rd(2, v); chk("R1 count 24 bit", v, 32'h5);
    // R8: writing 1 to a clear end flag does nothing
    wr(3, 32'h2); rd(3, v); chk("R8 end write one", v, 0);
    wr(8, 1);

    // sweep over sizes and step modes (R2 R3 R6 R11)
    for (int ts = 0; ts < 4; ts++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++) begin
          wr(3, 0);
          for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i * 7 + ts * 13 + sm * 5 + dm);
            refm[i] = 8'(i * 7 + ts * 13 + sm * 5 + dm);
          end
          nb = (ts == 3) ? 16 : (1 << ts);
          s = (sm == 2) ? 'h70 : 'h40;
          d = (dm == 2) ? 'hE0 : 'hA0;
          wr(0, 32'(s)); wr(1, 32'(d)); wr(2, 3);
          seen_rd = 1'b0;
          wr(3, EN | AUTO | 32'(ts << 10) | 32'(sm << 12) | 32'(dm << 14));
          for (int u = 0; u < 3; u++) begin
            for (int b = 0; b < nb; b++) refm[(d + b) & 255] = refm[(s + b) & 255];
            if (ts == 3) s += 16;
            else if (sm == 1) s += nb;
            else if (sm == 2) s -= nb;
            if (dm == 1) d += nb;
            else if (dm == 2) d -= nb;
          end
          wait_end(0, "R6 sweep finish");
          bad = 0;
          for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
          chk($sformatf("R2 R11 data ts%0d sm%0d dm%0d", ts, sm, dm), 32'(bad), 0);
          rd(0, v); chk($sformatf("R3 source ts%0d sm%0d", ts, sm), v, 32'(s));
          rd(1, v); chk($sformatf("R3 dest ts%0d dm%0d", ts, dm), v, 32'(d));
          rd(2, v); chk("R6 count zero", v, 0);
          chk("R2 first read address", first_rd, (sm == 2) ? 32'h70 : 32'h40);
        end

    // R4: end flag still set blocks arming
    wr(2, 2); wr(3, EN | AUTO | 32'h2);
    idle(30); rd(2, v); chk("R4 end flag blocks", v, 2);
    rd(3, v); chk("R8 write one keeps flag", 32'(v[1]), 1);
    // R4: global enable off blocks arming
    wr(8, 0); wr(3, EN | AUTO);
    idle(30); rd(2, v); chk("R4 global off blocks", v, 2);
    // R5: rising global enable arms
    wr(8, 1); wait_end(0, "R5 rise arms");
    rd(2, v); chk("R5 rise arms count", v, 0);

    // R9: interrupt level and vector
    wr(9, 32'hC5); wr(11, 32'h3A); wr(3, 0);
    wr(0, 32'h10); wr(1, 32'h80); wr(2, 1);
    ic = irq_cnt;
    wr(3, EN | AUTO | IE);
    wait_end(0, "R9 finish"); idle(2);
    chk("R9 irq count", 32'(irq_cnt - ic), 1);
    chk("R9 irq level", 32'(last_lvl), 32'hA);
    chk("R9 irq vector", 32'(last_vec), 32'h45);
    // R9: no interrupt without enable
    wr(3, 0); wr(2, 1); ic = irq_cnt;
    wr(3, EN | AUTO); wait_end(0, "R9 silent finish"); idle(2);
    chk("R9 no irq when disabled", 32'(irq_cnt - ic), 0);

    // R6: zero count finishes with no bus access
    wr(3, 0); wr(2, 0); seen_rd = 1'b0;
    wr(3, EN | AUTO); wait_end(0, "R6 zero count");
    chk("R6 zero count no access", 32'(seen_rd), 0);

    // R7: request pacing on channel 1
    wr(7, 0); wr(4, 32'h40); wr(5, 32'hA0); wr(6, 2);
    wr(7, EN | 32'h1000 | 32'h4000);
    idle(30); rd(6, v); chk("R7 waits for request", v, 2);
    pulse_dreq(1); idle(20);
    rd(6, v); chk("R7 one unit per request", v, 1);
    rd(7, v); chk("R7 not yet ended", 32'(v[1]), 0);
    pulse_dreq(1); wait_end(1, "R7 finish");
    rd(4, v); chk("R7 source stepped", v, 32'h42);

    // R10: channel 0 preferred
    wr(8, 0); wr(3, 0); wr(7, 0);
    wr(0, 32'h10); wr(1, 32'h90); wr(2, 1);
    wr(4, 32'h20); wr(5, 32'hB0); wr(6, 1);
    wr(3, EN | AUTO); wr(7, EN | AUTO);
    seen_rd = 1'b0;
    wr(8, 1);
    wait_end(0, "R10 ch0"); wait_end(1, "R10 ch1");
    chk("R10 channel 0 first", first_rd, 32'h10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule